// File: doc/BRIEF.md
# Split-Transaction Read Bus Controller

This block joins several read masters to one memory target over a shared bus that carries split transactions. A master asks for a read with an address. Once it wins arbitration, the request goes to memory with a tag, and the bus is free again on the next cycle. The memory later returns a reply with that same tag and the data. The controller sends the reply back to the master that the tag names. While earlier reads are still in flight, other masters can keep issuing requests.

A tag is the master index with a slot number appended. Each master owns a fixed number of slots, which is its limit on reads in flight. When all of a master's slots are taken, that master sits out of arbitration until a reply frees one. Only one transfer uses the shared bus in a cycle. If a reply and a request both want it, the reply goes first. Among the masters that can issue, requests are served round-robin.

Top module: `split_bus_ctrl`

## Requirements
- R1: After reset no grant, request-forwarding pulse or reply pulse is active, and every master has all of its slots free.
- R2: When master i is granted in cycle t, `mem_req_valid` is high in cycle t+1 and `mem_req_addr` equals master i's address from cycle t.
- R3: The forwarded tag is the master index in bits [TW-1:SW] and the slot number in bits [SW-1:0]. The slot is the lowest-numbered free slot of that master.
- R4: At most one bit of `m_gnt` is high in any cycle, and only for a master whose `m_req` is high.
- R5: A master with MAXO reads in flight (2 by default) receives no grant, even while it requests.
- R6: In a cycle where `mem_rsp_valid` is high, `m_gnt` is all zero.
- R7: Among requesting masters with a free slot, the grant goes to the first one found after the last granted master, searching upward in index order and wrapping around. After reset, master 0 has the highest priority.
- R8: A reply accepted in cycle t raises `m_rvalid` in cycle t+1 for one cycle, only on the master named by tag bits [TW-1:SW]. `m_rdata` carries the reply data in that same cycle.
- R9: A reply accepted in cycle t frees its slot, so from cycle t+1 the master can be granted again and the slot can be reused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| m_req | input | NM | Read request, one bit per master |
| m_addr | input | NM*AW | Read address, AW bits per master, master i at [i*AW +: AW] |
| m_gnt | output | NM | Same-cycle acceptance of a master's request |
| m_rvalid | output | NM | One-cycle reply pulse to the owning master |
| m_rdata | output | DW | Reply data, valid with `m_rvalid` |
| mem_req_valid | output | 1 | Request transfer to memory |
| mem_req_tag | output | TW | Tag of the forwarded request |
| mem_req_addr | output | AW | Address of the forwarded request |
| mem_rsp_valid | input | 1 | Reply transfer from memory |
| mem_rsp_tag | input | TW | Tag of the reply |
| mem_rsp_data | input | DW | Data of the reply |

## Verification
The grant comes from combinational logic on the current cycle's requests, reply valid and slot state. The forwarded request and the routed reply each appear exactly one cycle after the edge that accepts them. The bench changes its inputs at the falling edge and compares `m_gnt` one time unit later against an arithmetic prediction made from its own slot table and round-robin pointer. At the next falling edge it compares the registered memory-side and master-side outputs with the values it predicted in the cycle before. A fixed-latency memory in the bench replies to each captured request, with an optional hold to drive masters to their slot limit.

// File: rtl/split_bus_ctrl.sv
module split_bus_ctrl #(
  parameter int NM   = 4,
  parameter int AW   = 16,
  parameter int DW   = 32,
  parameter int MAXO = 2,
  localparam int MIW = (NM > 1) ? $clog2(NM) : 1,
  localparam int SW  = (MAXO > 1) ? $clog2(MAXO) : 1,
  localparam int TW  = MIW + SW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NM-1:0]    m_req,
  input  logic [NM*AW-1:0] m_addr,
  output logic [NM-1:0]    m_gnt,
  output logic [NM-1:0]    m_rvalid,
  output logic [DW-1:0]    m_rdata,
  output logic             mem_req_valid,
  output logic [TW-1:0]    mem_req_tag,
  output logic [AW-1:0]    mem_req_addr,
  input  logic             mem_rsp_valid,
  input  logic [TW-1:0]    mem_rsp_tag,
  input  logic [DW-1:0]    mem_rsp_data
);

  localparam int NSLOT = NM * (1 << SW);

  logic [NSLOT-1:0] busy, busy_nx;
  logic [MIW-1:0]   last;
  logic [NM-1:0]    elig, cand;
  logic             found;
  logic [MIW-1:0]   win;
  logic [SW-1:0]    slot;
  logic [TW-1:0]    new_tag;

  // a master may issue while any of its slots is free
  always_comb begin
    for (int i = 0; i < NM; i++) begin
      elig[i] = 1'b0;
      for (int s = 0; s < MAXO; s++)
        if (!busy[i*(1<<SW)+s]) elig[i] = 1'b1;
    end
  end

  assign cand = m_req & elig & {NM{~mem_rsp_valid}};

  always_comb begin
    found = 1'b0;
    win   = '0;
    for (int k = 1; k <= NM; k++) begin
      int j;
      j = (int'(last) + k) % NM;
      if (!found && cand[j]) begin
        found = 1'b1;
        win   = MIW'(j);
      end
    end
  end

  always_comb begin
    slot = '0;
    for (int s = MAXO - 1; s >= 0; s--)
      if (!busy[int'(win)*(1<<SW)+s]) slot = SW'(s);
  end

  assign new_tag = {win, slot};
  assign m_gnt   = found ? (NM'(1) << win) : '0;

  always_comb begin
    busy_nx = busy;
    if (mem_rsp_valid) busy_nx[mem_rsp_tag] = 1'b0;
    if (found)         busy_nx[new_tag]     = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy          <= '0;
      last          <= MIW'(NM - 1);
      mem_req_valid <= 1'b0;
      mem_req_tag   <= '0;
      mem_req_addr  <= '0;
      m_rvalid      <= '0;
      m_rdata       <= '0;
    end else begin
      busy          <= busy_nx;
      mem_req_valid <= found;
      if (found) begin
        last         <= win;
        mem_req_tag  <= new_tag;
        mem_req_addr <= m_addr[int'(win)*AW +: AW];
      end
      m_rvalid <= mem_rsp_valid ? (NM'(1) << mem_rsp_tag[TW-1:SW]) : '0;
      if (mem_rsp_valid) m_rdata <= mem_rsp_data;
    end
  end

  assert_one_grant_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(m_gnt));
  assert_grant_needs_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (m_gnt & ~m_req) == '0);
  assert_reply_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_valid |-> m_gnt == '0);
  assert_forward_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (m_gnt != '0) |=> mem_req_valid);
  assert_slot_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> busy[mem_req_tag]);
  assert_route_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_valid |=> m_rvalid == (NM'(1) << $past(mem_rsp_tag[TW-1:SW])));
  assert_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(m_rvalid));
  assert_reply_known_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_valid |-> busy[mem_rsp_tag]);

endmodule

// File: tb/split_bus_ctrl_tb.sv
module split_bus_ctrl_tb;
  localparam int CLK_P = 10;
  localparam int NM = 4, AW = 16, DW = 32, MAXO = 2, TW = 3, LAT = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NM-1:0] m_req = '0;
  logic [NM*AW-1:0] m_addr = '0;
  logic [NM-1:0] m_gnt, m_rvalid;
  logic [DW-1:0] m_rdata;
  logic mem_req_valid;
  logic [TW-1:0] mem_req_tag;
  logic [AW-1:0] mem_req_addr;
  logic mem_rsp_valid = 1'b0;
  logic [TW-1:0] mem_rsp_tag = '0;
  logic [DW-1:0] mem_rsp_data = '0;

  always #(CLK_P/2) clk = ~clk;

  split_bus_ctrl #(.NM(NM), .AW(AW), .DW(DW), .MAXO(MAXO)) u_dut (
    .clk(clk), .rst_n(rst_n), .m_req(m_req), .m_addr(m_addr), .m_gnt(m_gnt),
    .m_rvalid(m_rvalid), .m_rdata(m_rdata), .mem_req_valid(mem_req_valid),
    .mem_req_tag(mem_req_tag), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_tag(mem_rsp_tag),
    .mem_rsp_data(mem_rsp_data));

  int nvec = 0, nerr = 0, cyc = 0;
  bit mb [NM][MAXO];
  int last = NM - 1;
  logic [AW-1:0] taddr [8];
  bit exp_mv = 0;
  logic [TW-1:0] exp_mtag = '0;
  logic [AW-1:0] exp_maddr = '0;
  logic [NM-1:0] exp_rv = '0;
  logic [DW-1:0] exp_rd = '0;
  logic [NM-1:0] freed = '0;
  logic [TW-1:0] q_tag [64];
  logic [AW-1:0] q_addr [64];
  int q_due [64];
  int qh = 0, qt = 0;

  function automatic logic [DW-1:0] mdata(logic [AW-1:0] a, logic [TW-1:0] t);
    return {a ^ 16'hC3A5, 13'h0, t};
  endfunction

  task automatic chk(bit ok, string rq, logic [63:0] act, logic [63:0] exp);
    nvec++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s cycle %0d: actual %0h expected %0h", rq, cyc, act, exp);
    end
  endtask

  task automatic step(logic [NM-1:0] rq, bit hold);
    logic [NM-1:0] eg;
    int w, sl;
    bit masked;
    @(negedge clk);
    chk(mem_req_valid == exp_mv, "R2 valid", 64'(mem_req_valid), 64'(exp_mv));
    if (exp_mv) begin
      chk(mem_req_addr == exp_maddr, "R2 addr", 64'(mem_req_addr), 64'(exp_maddr));
      chk(mem_req_tag == exp_mtag, "R3 tag", 64'(mem_req_tag), 64'(exp_mtag));
    end
    chk(m_rvalid == exp_rv, "R8 rvalid", 64'(m_rvalid), 64'(exp_rv));
    if (exp_rv != '0) chk(m_rdata == exp_rd, "R8 rdata", 64'(m_rdata), 64'(exp_rd));
    if (mem_req_valid) begin
      q_tag[qt % 64] = mem_req_tag; q_addr[qt % 64] = mem_req_addr;
      q_due[qt % 64] = cyc + LAT; qt++;
    end
    m_req = rq;
    for (int i = 0; i < NM; i++) m_addr[i*AW +: AW] = AW'((cyc * 16 + i * 5) & 16'hFFFF);
    mem_rsp_valid = 1'b0;
    if (!hold && qh != qt && q_due[qh % 64] <= cyc) begin
      mem_rsp_valid = 1'b1;
      mem_rsp_tag = q_tag[qh % 64];
      mem_rsp_data = mdata(q_addr[qh % 64], q_tag[qh % 64]);
      qh++;
    end
    #1;
    eg = '0; w = -1; masked = 0;
    if (!mem_rsp_valid) begin
      for (int k = 1; k <= NM; k++) begin
        int j;
        j = (last + k) % NM;
        if (rq[j] && mb[j][0] && mb[j][1]) masked = 1;
        if (w < 0 && rq[j] && !(mb[j][0] && mb[j][1])) w = j;
      end
      if (w >= 0) eg[w] = 1'b1;
    end
    if (mem_rsp_valid)            chk(m_gnt == eg, "R6", 64'(m_gnt), 64'(eg));
    else if ((rq & freed) != '0)  chk(m_gnt == eg, "R9", 64'(m_gnt), 64'(eg));
    else if (masked)              chk(m_gnt == eg, "R5", 64'(m_gnt), 64'(eg));
    else                          chk(m_gnt == eg, "R7 R4", 64'(m_gnt), 64'(eg));
    freed = '0;
    exp_rv = '0;
    if (mem_rsp_valid) begin
      mb[mem_rsp_tag >> 1][mem_rsp_tag & 1] = 0;
      exp_rv[mem_rsp_tag >> 1] = 1'b1;
      exp_rd = mdata(taddr[mem_rsp_tag], mem_rsp_tag);
      freed[mem_rsp_tag >> 1] = 1'b1;
    end
    exp_mv = (w >= 0);
    if (w >= 0) begin
      sl = mb[w][0] ? 1 : 0;
      mb[w][sl] = 1;
      exp_mtag = TW'(w * 2 + sl);
      exp_maddr = m_addr[w*AW +: AW];
      taddr[w*2+sl] = exp_maddr;
      last = w;
    end
    cyc++;
  endtask

  initial begin
    #(CLK_P * 150000);
    nerr++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    logic [15:0] lf;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(m_gnt == '0, "R1 gnt", 64'(m_gnt), 0);
    chk(mem_req_valid == 1'b0, "R1 mreq", 64'(mem_req_valid), 0);
    chk(m_rvalid == '0, "R1 rvalid", 64'(m_rvalid), 0);
    m_req = 4'hF; #1;
    chk(m_gnt == 4'b0001, "R1 R7 first", 64'(m_gnt), 1);
    m_req = '0;
    for (int rep = 0; rep < 4; rep++)
      for (int p = 0; p < 16; p++) step(4'(p), 0);
    for (int n = 0; n < 12; n++) step(4'hF, 1);
    for (int n = 0; n < 40; n++) step(4'hF, 0);
    for (int n = 0; n < 10; n++) step(4'b0101, 1);
    for (int n = 0; n < 20; n++) step(4'b0110, 0);
    lf = 16'hACE1;
    for (int n = 0; n < 1500; n++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      step(lf[3:0], lf[7:5] == 3'b000);
    end
    for (int n = 0; n < 40; n++) step('0, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule